// File: doc/BRIEF.md
# SDRAM Special Command Trigger

This block sits between a bus-access front end and an SDRAM command sequencer for one SDRAM block. It holds a small control register. The register has a 3-bit address-mux code, a 2-bit port-size code and two one-shot request bits. One request bit asks for a mode-register load and the other asks for a precharge of all banks. While a request bit is armed, the next qualifying bus access to the block is turned into that special command instead of a normal read or write. For a mode-register load, the access address carries the mode value to the sequencer. The special access is acknowledged without a data transfer.

The mux code places the command bit and the bank-select field in the access address. Every access sent to the sequencer carries the decoded bank, the command bit and the port width. After the block issues a special command, it stalls further accesses until the sequencer signals completion. That completion clears the request bit that was served.

Top module: `sdram_cmd_trigger`

## Requirements
- R1: The command bit output equals access address bit 17+M, where M is the 3-bit mux code held in register bits [2:0]. Code 0 gives bit 17 and code 7 gives bit 24.
- R2: The bank output equals the BANK_W address bits that start at bit 18+M, which is the bit just above the command bit.
- R3: While the mode-load request (register bit 6) is armed, the next accepted access issues command kind 3. This holds for reads and for writes, unless R5 applies. The access address passes unchanged to cmd_addr, and acc_nodata is high in that cycle.
- R4: While the precharge-all request (register bit 5) is armed, the next accepted write issues command kind 2. A read with only this request armed passes through as a normal read.
- R5: When both requests are armed, a write issues the precharge-all command and a read issues the mode-load command. Each request is served by its own access.
- R6: A cmd_done pulse that arrives while a special command is in flight clears only the request bit of that command. The other request bit keeps its value.
- R7: From the cycle after a special command is issued until the cycle after cmd_done, acc_ready is low and no command is produced.
- R8: With no request bit involved, an access issues kind 0 for a read or kind 1 for a write. The port-size code in register bits [4:3] sets cmd_width: 00 gives 2 (32-bit), 01 gives 0 (8-bit), and 10 or 11 gives 1 (16-bit).
- R9: After reset the register reads zero. Bit 7 always reads zero, and writes to it have no effect.
- R10: A register write in the same cycle as cmd_done takes precedence. The written value is read back in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read value |
| acc_valid | input | 1 | Bus access present |
| acc_write | input | 1 | Access direction, 1 = write |
| acc_addr | input | ADDR_W | Access address |
| acc_ready | output | 1 | Block can accept an access |
| acc_nodata | output | 1 | Accepted access became a special command, so no data moves |
| cmd_valid | output | 1 | Command to sequencer |
| cmd_kind | output | 2 | 0 read, 1 write, 2 precharge-all, 3 mode load |
| cmd_addr | output | ADDR_W | Address, which carries the mode value for kind 3 |
| cmd_sel_bit | output | 1 | Decoded command bit |
| cmd_bank | output | BANK_W | Decoded bank select |
| cmd_width | output | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| cmd_done | input | 1 | Sequencer finished the special command |

## Verification
The assertions assume that the sequencer pulses cmd_done only while a special command is in flight. They also assume that a register write does not arrive in the same cycle as the access that fires a special command. The stimulus drives inputs mid-cycle. It raises cmd_done only after a special command has been accepted, and it spaces register writes apart from accesses. A scoreboard predicts each command from the armed bits it tracks itself and compares the prediction field by field with what the block issues.

// File: rtl/sdram_cmd_trigger.sv
module sdram_cmd_trigger #(
  parameter int ADDR_W   = 32,
  parameter int CMD_BASE = 17,
  parameter int BANK_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ready,
  output logic              acc_nodata,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_sel_bit,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [1:0]        cmd_width,
  input  logic              cmd_done
);
  localparam int BANK_BASE = CMD_BASE + 1;

  logic [2:0] mux_q;
  logic [1:0] ps_q;
  logic       pall_q, mrs_q, busy_q, busy_mrs_q;
  logic       fire_pall, fire_mrs, accept;

  assign fire_pall = pall_q & acc_write;
  assign fire_mrs  = mrs_q & ~fire_pall;
  assign accept    = acc_valid & ~busy_q;

  assign cmd_kind    = fire_pall ? 2'd2 : fire_mrs ? 2'd3 : {1'b0, acc_write};
  assign cmd_valid   = accept;
  assign acc_ready   = ~busy_q;
  assign acc_nodata  = accept & cmd_kind[1];
  assign cmd_addr    = acc_addr;
  assign cmd_sel_bit = acc_addr[CMD_BASE + int'(mux_q)];
  assign cmd_bank    = BANK_W'(acc_addr >> (BANK_BASE + int'(mux_q)));
  assign cmd_width   = ps_q[1] ? 2'd1 : (ps_q[0] ? 2'd0 : 2'd2);
  assign cfg_rdata   = {1'b0, mrs_q, pall_q, ps_q, mux_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mux_q <= '0; ps_q <= '0; pall_q <= 1'b0; mrs_q <= 1'b0;
      busy_q <= 1'b0; busy_mrs_q <= 1'b0;
    end else begin
      if (accept && cmd_kind[1]) begin
        busy_q     <= 1'b1;
        busy_mrs_q <= cmd_kind[0];
      end else if (cmd_done) begin
        busy_q <= 1'b0;
      end
      if (cfg_we) begin
        {mrs_q, pall_q, ps_q, mux_q} <= cfg_wdata[6:0];
      end else if (busy_q && cmd_done) begin
        if (busy_mrs_q) mrs_q  <= 1'b0;
        else            pall_q <= 1'b0;
      end
    end
  end

  p_pall_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd2) |-> (acc_write && cfg_rdata[5]));
  p_mrs_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd3) |-> cfg_rdata[6]);
  p_stall_after_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind[1]) |=> !acc_ready);
  p_hold_until_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_ready && !cmd_done) |=> (!acc_ready && !cmd_valid));
  p_mrs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && busy_mrs_q && cmd_done && !cfg_we) |=> (!cfg_rdata[6] && $stable(cfg_rdata[5])));
  p_pall_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !busy_mrs_q && cmd_done && !cfg_we) |=> (!cfg_rdata[5] && $stable(cfg_rdata[6])));
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == {1'b0, $past(cfg_wdata[6:0])}));
endmodule

// File: tb/sdram_cmd_trigger_test.sv
module sdram_cmd_trigger_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_ready, acc_nodata;
  logic [AW-1:0] acc_addr = '0, cmd_addr;
  logic cmd_valid, cmd_sel_bit, cmd_done = 1'b0;
  logic [1:0] cmd_kind, cmd_bank, cmd_width;

  sdram_cmd_trigger uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0] kind; logic [AW-1:0] addr; logic sel; logic [1:0] bank;
    logic [1:0] width; logic nodata;
  } exp_t;
  exp_t q[$];
  string tagq[$];

  int checks = 0, fails = 0, cycles = 0;
  logic [2:0] mux_m = '0;
  logic [1:0] ps_m = '0;
  logic pall_m = 1'b0, mrs_m = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    chk(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (q.size() == 0) chk(0, "R7 unexpected command", cmd_kind, 0);
      else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = tagq.pop_front();
        chk(cmd_kind == e.kind, {t, " kind"}, cmd_kind, e.kind);
        chk(cmd_addr == e.addr, {t, " addr"}, cmd_addr, e.addr);
        chk(cmd_sel_bit == e.sel, "R1 command bit", cmd_sel_bit, e.sel);
        chk(cmd_bank == e.bank, "R2 bank", cmd_bank, e.bank);
        chk(cmd_width == e.width, "R8 width", cmd_width, e.width);
        chk(acc_nodata == e.nodata, {t, " nodata"}, acc_nodata, e.nodata);
      end
    end
  end

  task automatic cfg_write(input logic [7:0] v);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_wdata = v;
    {mrs_m, pall_m, ps_m, mux_m} = v[6:0];
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input string tag);
    exp_t e;
    logic fp, fm;
    fp = pall_m & wr;
    fm = mrs_m & ~fp;
    e.kind = fp ? 2'd2 : fm ? 2'd3 : {1'b0, wr};
    e.addr = a;
    e.sel = a[17 + int'(mux_m)];
    e.bank = 2'((a >> (18 + int'(mux_m))) & 3);
    e.width = ps_m[1] ? 2'd1 : (ps_m[0] ? 2'd0 : 2'd2);
    e.nodata = fp | fm;
    @(posedge clk); #2;
    q.push_back(e); tagq.push_back(tag);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a;
    @(posedge clk); #2;
    acc_valid = 1'b0;
  endtask

  task automatic done_pulse(input logic was_mrs);
    @(posedge clk); #2;
    cmd_done = 1'b1;
    @(posedge clk); #2;
    cmd_done = 1'b0;
    if (was_mrs) mrs_m = 1'b0; else pall_m = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 8'h00, "R9 reset value", cfg_rdata, 0);
    chk(acc_ready == 1'b1, "R7 ready after reset", acc_ready, 1);

    cfg_write(8'hFF);
    @(negedge clk);
    chk(cfg_rdata == 8'h7F, "R9 reserved bit", cfg_rdata, 8'h7F);
    cfg_write(8'h03);

    // R1 R2 R8 normal traffic over several mux codes
    access(1'b0, 32'h00A5_5A5A, "R8 read");
    access(1'b1, 32'h0FF2_0000, "R8 write");
    cfg_write(8'h00);
    access(1'b1, 32'h0006_0000, "R1 code0");
    cfg_write(8'h07);
    access(1'b0, 32'h0300_0000 | 32'h0100_0000, "R2 code7");
    access(1'b0, 32'h0280_0000, "R2 code7b");
    cfg_write(8'h08); access(1'b0, 32'h1234_5678, "R8 ps01");
    cfg_write(8'h10); access(1'b1, 32'h1234_5678, "R8 ps10");
    cfg_write(8'h18); access(1'b0, 32'h8765_4321, "R8 ps11");

    // R3 mode-load armed, fired by a read
    cfg_write(8'h42);
    access(1'b0, 32'h0000_0233, "R3 mode load");
    @(negedge clk);
    chk(acc_ready == 1'b0, "R7 stall", acc_ready, 0);
    @(posedge clk); #2; acc_valid = 1'b1; acc_write = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R7 no command while busy", cmd_valid, 0);
    @(posedge clk); #2; acc_valid = 1'b0;
    done_pulse(1'b1);
    @(negedge clk);
    chk(cfg_rdata == 8'h02, "R6 mode request cleared", cfg_rdata, 8'h02);
    chk(acc_ready == 1'b1, "R7 ready after done", acc_ready, 1);

    // R4 precharge only on a write
    cfg_write(8'h25);
    access(1'b0, 32'h0004_0000, "R4 read passes");
    @(negedge clk);
    chk(cfg_rdata == 8'h25, "R4 request kept after read", cfg_rdata, 8'h25);
    access(1'b1, 32'h0008_0000, "R4 precharge");
    done_pulse(1'b0);
    @(negedge clk);
    chk(cfg_rdata == 8'h05, "R6 precharge request cleared", cfg_rdata, 8'h05);

    // R5 both armed
    cfg_write(8'h61);
    access(1'b0, 32'h0000_0032, "R5 read gives mode load");
    done_pulse(1'b1);
    @(negedge clk);
    chk(cfg_rdata == 8'h21, "R6 precharge kept", cfg_rdata, 8'h21);
    access(1'b1, 32'h0010_0000, "R5 write gives precharge");
    done_pulse(1'b0);
    @(negedge clk);
    chk(cfg_rdata == 8'h01, "R5 both served", cfg_rdata, 8'h01);
    cfg_write(8'h61);
    access(1'b1, 32'h0020_0000, "R5 write first gives precharge");
    done_pulse(1'b0);
    @(negedge clk);
    chk(cfg_rdata == 8'h41, "R6 mode kept", cfg_rdata, 8'h41);

    // R10 write beats done in the same cycle
    access(1'b1, 32'h0000_0044, "R3 write gives mode load");
    @(posedge clk); #2;
    cmd_done = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'h44;
    @(posedge clk); #2;
    cmd_done = 1'b0; cfg_we = 1'b0;
    {mrs_m, pall_m, ps_m, mux_m} = 7'h44;
    @(negedge clk);
    chk(cfg_rdata == 8'h44, "R10 write wins", cfg_rdata, 8'h44);
    chk(acc_ready == 1'b1, "R7 ready after R10 done", acc_ready, 1);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule